// File: doc/BRIEF.md
# Double-Rate Crossing Record Link

This block moves one detector summary record per 40 MHz beam crossing across a 72-bit parallel link that runs at twice the crossing rate. Each record holds two 16-bit energy sums, one from each 24-channel group. It also holds a 2-bit status code for each of the 48 channels, a trigger-accept flag and an orbit-start flag. The transmit side splits every record into two 72-bit half-frames on consecutive link cycles. Both halves carry a 2-bit label in the same bit positions, so the far side can tell them apart. The receive side rebuilds the record, and it watches the labels to catch lost or shifted half-frames.

Both sides run on the link clock, at twice the crossing rate. The transmitter raises `tx_take` on every other link cycle. On the rising clock edge that ends such a cycle it captures the record on its inputs. The link output is `link_tx` and the link input is `link_rx`. They are separate ports so that the two ends can sit on different boards. For a self test they can be joined directly. The receiver starts out unlocked and waits for a first-half label. Once locked, any label it does not expect is reported on `frame_err`, and the partial record is thrown away. The receiver realigns on the next first-half label.

Top module: `dbl_rate_link`

## Requirements
- R1: During reset `link_tx` is all zero. The first link cycle after reset has `tx_take` high, and from then on `tx_take` alternates every cycle.
- R2: In the cycle after a take edge, `link_tx` carries the first half-frame. Bits [15:0] hold sum A and bits [31:16] hold sum B. Bit 32 is the trigger flag and bit 33 is the orbit flag. Bits [69:34] hold the codes of channels 0..17, with channel k at bits [35+2k:34+2k]. Bits [71:70] hold the label 01.
- R3: In the following cycle, `link_tx` carries the second half-frame. Bits [59:0] hold the codes of channels 18..47, with channel k at bits [2(k-18)+1:2(k-18)]. Bits [69:60] are zero. Bits [71:70] hold the label 10.
- R4: When `link_rx` follows `link_tx`, each captured record appears on the `rec_*` outputs bit-exact. `rec_valid` is high for one cycle, three link cycles after the cycle in which the record was presented with `tx_take` high.
- R5: `rec_valid` is raised only for a label-01 word that is immediately followed by a label-10 word. It is never high on two consecutive cycles.
- R6: After reset, and until the first label-01 word arrives, no label value raises `frame_err` or `rec_valid`.
- R7: Once a label-01 word has been accepted, a word whose label is not the one expected next raises `frame_err` for one cycle in the following cycle. The record that was being assembled is dropped and `rec_valid` stays low in that cycle.
- R8: After a framing error the receiver realigns on the next label-01 word. A label-01 word that arrives in place of a second half is itself taken as a new first half, so it raises `frame_err` and starts a new record at once. Records after the realignment are delivered intact.
- R9: Channel codes, including the dead code 00 and the code 11, and sums from 0 to all ones pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, twice the crossing rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sum_a | input | 16 | Energy sum of channel group A |
| sum_b | input | 16 | Energy sum of channel group B |
| codes | input | 96 | Channel status codes, channel k at bits [2k+1:2k] |
| trig | input | 1 | Trigger-accept flag of the crossing |
| orbit | input | 1 | Orbit-start flag of the crossing |
| tx_take | output | 1 | High in the cycles whose closing edge captures the inputs |
| link_tx | output | 72 | Transmit half-frame word |
| link_rx | input | 72 | Receive half-frame word |
| rec_valid | output | 1 | One-cycle strobe for a rebuilt record |
| rec_sum_a | output | 16 | Rebuilt sum A |
| rec_sum_b | output | 16 | Rebuilt sum B |
| rec_codes | output | 96 | Rebuilt channel codes |
| rec_trig | output | 1 | Rebuilt trigger flag |
| rec_orbit | output | 1 | Rebuilt orbit flag |
| frame_err | output | 1 | One-cycle strobe for a label out of sequence while locked |

## Verification
The assertions assume three things. The record inputs are stable around each edge where `tx_take` is high. `link_rx` changes only between clock edges. Reset is held for at least one edge. The bench drives every input on the falling edge, and it joins `link_rx` to `link_tx` combinationally. It damages only the label field, and only for a whole cycle at a time, so each damaged word lines up with exactly one known half-frame. That lets the reference model drop the one affected record and place the expected error strobes exactly. The first cycles after reset are muted with a bad label to exercise the unlocked state.

// File: rtl/dbl_rate_link_pkg.sv
package dbl_rate_link_pkg;

    localparam int LINK_W   = 72;
    localparam int SUM_W    = 16;
    localparam int CODE_W   = 2;
    localparam int N_CH     = 48;
    localparam int LBL_W    = 2;

    // derived layout
    localparam int CODES_W     = N_CH * CODE_W;
    localparam int LBL_LSB     = LINK_W - LBL_W;
    localparam int TRIG_BIT    = 2 * SUM_W;
    localparam int ORBIT_BIT   = 2 * SUM_W + 1;
    localparam int H0_CODE_LSB = 2 * SUM_W + 2;
    localparam int H0_CH       = (LBL_LSB - H0_CODE_LSB) / CODE_W;
    localparam int H0_CODE_W   = H0_CH * CODE_W;
    localparam int H1_CH       = N_CH - H0_CH;
    localparam int H1_CODE_W   = H1_CH * CODE_W;
    localparam int PAD_W       = LBL_LSB - H1_CODE_W;

    localparam logic [LBL_W-1:0] LBL_FIRST  = 2'b01;
    localparam logic [LBL_W-1:0] LBL_SECOND = 2'b10;

    typedef struct packed {
        logic [SUM_W-1:0]   sum_a;
        logic [SUM_W-1:0]   sum_b;
        logic [CODES_W-1:0] codes;
        logic               trig;
        logic               orbit;
    } xrec_t;

    typedef enum logic [1:0] {
        RX_SEEK  = 2'd0,
        RX_WANT1 = 2'd1,
        RX_WANT0 = 2'd2
    } rx_state_t;

    function automatic logic [LINK_W-1:0] build_first(input xrec_t r);
        logic [LINK_W-1:0] w;
        w = '0;
        w[SUM_W-1:0]                 = r.sum_a;
        w[2*SUM_W-1:SUM_W]           = r.sum_b;
        w[TRIG_BIT]                  = r.trig;
        w[ORBIT_BIT]                 = r.orbit;
        w[H0_CODE_LSB +: H0_CODE_W]  = r.codes[H0_CODE_W-1:0];
        w[LBL_LSB +: LBL_W]          = LBL_FIRST;
        return w;
    endfunction

    function automatic logic [LINK_W-1:0] build_second(input xrec_t r);
        logic [LINK_W-1:0] w;
        w = '0;
        w[H1_CODE_W-1:0]    = r.codes[CODES_W-1:H0_CODE_W];
        w[LBL_LSB +: LBL_W] = LBL_SECOND;
        return w;
    endfunction

    function automatic xrec_t join_halves(input logic [LBL_LSB-1:0] h0,
                                          input logic [LINK_W-1:0]  h1);
        xrec_t r;
        r.sum_a = h0[SUM_W-1:0];
        r.sum_b = h0[2*SUM_W-1:SUM_W];
        r.trig  = h0[TRIG_BIT];
        r.orbit = h0[ORBIT_BIT];
        r.codes = {h1[H1_CODE_W-1:0], h0[H0_CODE_LSB +: H0_CODE_W]};
        return r;
    endfunction

endpackage

// File: rtl/drl_packer.sv
module drl_packer
    import dbl_rate_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  xrec_t             rec_i,
    output logic              take_o,
    output logic [LINK_W-1:0] link_o
);

    typedef struct packed {
        logic              phase;   // 0: capture cycle, 1: second-half cycle
        xrec_t             hold;
        logic [LINK_W-1:0] link;
    } pk_state_t;

    pk_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.phase = ~st_q.phase;
        if (!st_q.phase) begin
            st_d.hold = rec_i;
            st_d.link = build_first(rec_i);
        end else begin
            st_d.link = build_second(st_q.hold);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take_o = ~st_q.phase;
    assign link_o = st_q.link;

    AST_TAKE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o) else $error("take strobe repeated"); // R1

    AST_FIRST_LABEL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(take_o)) |-> (link_o[LBL_LSB +: LBL_W] == LBL_FIRST))
        else $error("first half label wrong"); // R2

    AST_SECOND_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(take_o)) |->
            (link_o[LBL_LSB +: LBL_W] == LBL_SECOND && link_o[H1_CODE_W +: PAD_W] == '0))
        else $error("second half label or padding wrong"); // R3

endmodule

// File: rtl/drl_unpacker.sv
module drl_unpacker
    import dbl_rate_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINK_W-1:0] link_i,
    output logic              valid_o,
    output xrec_t             rec_o,
    output logic              err_o
);

    typedef struct packed {
        rx_state_t          state;
        logic [LBL_LSB-1:0] part;
        xrec_t              rec;
        logic               valid;
        logic               err;
    } rx_reg_t;

    rx_reg_t rx_d, rx_q;
    logic [LBL_W-1:0] lbl;

    assign lbl = link_i[LBL_LSB +: LBL_W];

    always_comb begin
        rx_d       = rx_q;
        rx_d.valid = 1'b0;
        rx_d.err   = 1'b0;
        case (rx_q.state)
            RX_SEEK: begin
                if (lbl == LBL_FIRST) begin
                    rx_d.part  = link_i[LBL_LSB-1:0];
                    rx_d.state = RX_WANT1;
                end
            end
            RX_WANT1: begin
                if (lbl == LBL_SECOND) begin
                    rx_d.rec   = join_halves(rx_q.part, link_i);
                    rx_d.valid = 1'b1;
                    rx_d.state = RX_WANT0;
                end else begin
                    rx_d.err = 1'b1;
                    if (lbl == LBL_FIRST) begin
                        rx_d.part  = link_i[LBL_LSB-1:0];
                        rx_d.state = RX_WANT1;
                    end else begin
                        rx_d.state = RX_SEEK;
                    end
                end
            end
            RX_WANT0: begin
                if (lbl == LBL_FIRST) begin
                    rx_d.part  = link_i[LBL_LSB-1:0];
                    rx_d.state = RX_WANT1;
                end else begin
                    rx_d.err   = 1'b1;
                    rx_d.state = RX_SEEK;
                end
            end
            default: rx_d.state = RX_SEEK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign valid_o = rx_q.valid;
    assign rec_o   = rx_q.rec;
    assign err_o   = rx_q.err;

    AST_VALID_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o) else $error("valid on consecutive cycles"); // R5

    AST_VALID_AFTER_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(link_i[LBL_LSB +: LBL_W] == LBL_SECOND))
        else $error("valid without second-half label"); // R5

    AST_ERR_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(rx_q.state != RX_SEEK)) else $error("error while unlocked"); // R6

    AST_ERR_DROPS_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !valid_o) else $error("error and valid together"); // R7

endmodule

// File: rtl/dbl_rate_link.sv
module dbl_rate_link
    import dbl_rate_link_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SUM_W-1:0]    sum_a,
    input  logic [SUM_W-1:0]    sum_b,
    input  logic [CODES_W-1:0]  codes,
    input  logic                trig,
    input  logic                orbit,
    output logic                tx_take,
    output logic [LINK_W-1:0]   link_tx,
    input  logic [LINK_W-1:0]   link_rx,
    output logic                rec_valid,
    output logic [SUM_W-1:0]    rec_sum_a,
    output logic [SUM_W-1:0]    rec_sum_b,
    output logic [CODES_W-1:0]  rec_codes,
    output logic                rec_trig,
    output logic                rec_orbit,
    output logic                frame_err
);

    xrec_t tx_rec, rx_rec;

    always_comb begin
        tx_rec.sum_a = sum_a;
        tx_rec.sum_b = sum_b;
        tx_rec.codes = codes;
        tx_rec.trig  = trig;
        tx_rec.orbit = orbit;
    end

    drl_packer u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .rec_i  (tx_rec),
        .take_o (tx_take),
        .link_o (link_tx)
    );

    drl_unpacker u_unpack (
        .clk     (clk),
        .rst_n   (rst_n),
        .link_i  (link_rx),
        .valid_o (rec_valid),
        .rec_o   (rx_rec),
        .err_o   (frame_err)
    );

    assign rec_sum_a = rx_rec.sum_a;
    assign rec_sum_b = rx_rec.sum_b;
    assign rec_codes = rx_rec.codes;
    assign rec_trig  = rx_rec.trig;
    assign rec_orbit = rx_rec.orbit;

endmodule

// File: tb/sim_dbl_rate_link.sv
module sim_dbl_rate_link;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    typedef struct packed {
        logic [15:0] a;
        logic [15:0] b;
        logic [95:0] c;
        logic        t;
        logic        o;
    } brec_t;

    logic        rst_n;
    logic [15:0] sum_a, sum_b;
    logic [95:0] codes;
    logic        trig, orbit;
    logic        tx_take;
    logic [71:0] link_tx, link_rx;
    logic        rec_valid;
    logic [15:0] rec_sum_a, rec_sum_b;
    logic [95:0] rec_codes;
    logic        rec_trig, rec_orbit;
    logic        frame_err;
    logic        ovr;
    logic [1:0]  ovr_lbl;

    dbl_rate_link u0 (
        .clk(clk), .rst_n(rst_n),
        .sum_a(sum_a), .sum_b(sum_b), .codes(codes), .trig(trig), .orbit(orbit),
        .tx_take(tx_take), .link_tx(link_tx), .link_rx(link_rx),
        .rec_valid(rec_valid), .rec_sum_a(rec_sum_a), .rec_sum_b(rec_sum_b),
        .rec_codes(rec_codes), .rec_trig(rec_trig), .rec_orbit(rec_orbit),
        .frame_err(frame_err)
    );

    assign link_rx = {(ovr ? ovr_lbl : link_tx[71:70]), link_tx[69:0]};

    brec_t expq[$];
    int    expc[$];
    int    errq[$];
    brec_t last_rec;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic brec_t make_rec(input int c);
        brec_t r;
        if (c >= 100 && c < 140) begin
            r = '0;                                  // all channels dead, zero sums
        end else if (c >= 140 && c < 180) begin
            r = '1;                                  // code 11 everywhere, full sums
        end else begin
            r.a = 16'($urandom);
            r.b = 16'($urandom);
            r.c = {$urandom, $urandom, $urandom};
            r.t = 1'($urandom);
            r.o = 1'($urandom);
        end
        return r;
    endfunction

    task automatic cycle(input int c);
        bit    mute, want_err;
        brec_t r, e;
        string rq;
        // receive side against the reference model
        if (expc.size() > 0 && expc[0] == c) begin
            e = expq.pop_front();
            void'(expc.pop_front());
            rq = (e == '0 || e == '1) ? "R9" : "R4";
            chk(rec_valid == 1'b1, "R4", "rec_valid at due cycle", 128'(rec_valid), 128'd1);
            chk({rec_sum_a, rec_sum_b, rec_codes, rec_trig, rec_orbit} == e,
                rq, "rebuilt record",
                128'({rec_sum_a, rec_sum_b, rec_codes, rec_trig, rec_orbit}), 128'(e));
        end else begin
            chk(rec_valid == 1'b0, "R5", "no rec_valid", 128'(rec_valid), 128'd0);
        end
        want_err = (errq.size() > 0 && errq[0] == c);
        if (want_err) void'(errq.pop_front());
        chk(frame_err == want_err, (c < 10) ? "R6" : "R7", "frame_err",
            128'(frame_err), 128'(want_err));
        // transmit side
        chk(tx_take == (c % 2 == 0), "R1", "tx_take alternation",
            128'(tx_take), 128'(c % 2 == 0));
        if (!tx_take) begin
            chk(link_tx == {2'b01, last_rec.c[35:0], last_rec.o, last_rec.t, last_rec.b, last_rec.a},
                "R2", "first half layout", 128'(link_tx),
                128'({2'b01, last_rec.c[35:0], last_rec.o, last_rec.t, last_rec.b, last_rec.a}));
        end else if (c > 0) begin
            chk(link_tx == {2'b10, 10'd0, last_rec.c[95:36]}, "R3", "second half layout",
                128'(link_tx), 128'({2'b10, 10'd0, last_rec.c[95:36]}));
        end
        // label damage schedule
        mute = (c < 8);
        ovr     = 1'b0;
        ovr_lbl = 2'b00;
        if (mute) begin
            ovr = 1'b1; ovr_lbl = 2'b11;             // R6: unlocked, bad labels ignored
        end
        if (c == 200) begin                          // R7: damaged second half
            ovr = 1'b1; ovr_lbl = 2'b00;
            void'(expq.pop_back()); void'(expc.pop_back());
            errq.push_back(c + 1);
        end
        if (c == 301) begin                          // R7: damaged first half
            ovr = 1'b1; ovr_lbl = 2'b11;
            void'(expq.pop_back()); void'(expc.pop_back());
            errq.push_back(c + 1);
        end
        if (c == 402) begin                          // R8: first label in place of second
            ovr = 1'b1; ovr_lbl = 2'b01;
            void'(expq.pop_back()); void'(expc.pop_back());
            errq.push_back(c + 1);
            errq.push_back(c + 2);
        end
        // new record
        r = make_rec(c);
        {sum_a, sum_b, codes, trig, orbit} = r;
        if (tx_take) begin
            last_rec = r;
            if (!mute) begin
                expq.push_back(r);
                expc.push_back(c + 3);
            end
        end
    endtask

    initial begin
        rst_n = 1'b0;
        ovr = 1'b0; ovr_lbl = 2'b00;
        {sum_a, sum_b, codes, trig, orbit} = '0;
        last_rec = '0;
        repeat (3) @(negedge clk);
        chk(link_tx == 72'd0, "R1", "link_tx in reset", 128'(link_tx), 128'd0);
        chk(rec_valid == 1'b0 && frame_err == 1'b0, "R6", "strobes in reset",
            128'({rec_valid, frame_err}), 128'd0);
        rst_n = 1'b1;
        for (int c = 0; c < 600; c++) begin
            if (c > 0) @(negedge clk);
            cycle(c);
        end
        chk(expq.size() <= 2, "R8", "records left undelivered", 128'(expq.size()), 128'd2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R4 watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule